// File: doc/BRIEF.md
# Receive Frame Status Queue

This block sits beside a high-speed infrared receiver and keeps one record per finished incoming frame, so that software can match received bytes to frame boundaries after several frames have arrived back to back. A record holds either the frame's receiver flags and its 16-bit byte length, or the number of frames that had to be dropped while the queue had no room. The queue is eight records deep by default.

The receiver strobes `frm_done` with the flags and length at the end of every frame. Records are taken only while `dma_en` is high, no matter which agent moves the received data bytes. The host looks at the oldest record through one byte-wide read port and selects one of three views: status, length low byte (or the lost count), or length high byte. A strobe on the length-high view removes the record. An interrupt line combines a fill-level threshold with an idle timeout. While the queue is full, `frm_reject` tells the receiver to drop new frames. Those frames are counted and later reported as a single lost-frame record.

Top module: `rx_frame_status_fifo`

## Requirements
- R1: After `rst_n` is low, and in the cycle after `soft_rst` is high, the queue is empty, no lost count is pending, and `irq` and `frm_reject` are 0. A record read while the queue is empty returns 0 on every view.
- R2: A `frm_done` pulse while `dma_en` is 1 and no rejection is active appends a record. Records are read in arrival order. The status view (`rd_sel`=0) returns {bit7=0, bit6=1 (valid), bits5:0=`frm_flags`}. View 1 returns `frm_len[7:0]`. View 2 returns `frm_len[15:8]`. View 3 always returns 0.
- R3: A `frm_done` pulse while `dma_en` is 0 neither adds a record nor counts as lost.
- R4: The oldest record is removed only by `rd_en`=1 with `rd_sel`=2. Strobes on views 0, 1 and 3 leave the queue unchanged.
- R5: The queue holds DEPTH (8) records. While it is full, `frm_reject` is 1, and each `frm_done` with `dma_en`=1 is counted as lost instead of being stored.
- R6: When room appears and the lost count is nonzero, one lost-frame record is appended ahead of any later frame. Its status view is 8'hC0 (bit7 marks lost, bit6 valid), view 1 holds the count, and view 2 holds 0. The count saturates at 255. While a count is pending, `frm_reject` stays 1.
- R7: `irq` is 1 while the fill level is at least the threshold selected by `thr_sel` (0 means 1 record, 1 means 2, 2 or 3 means 4). It falls as soon as the level drops below the threshold.
- R8: The idle counter restarts on every append or removal. When the queue stays non-empty for `tmo_limit`+1 cycles with no append or removal, a timeout flag sets and drives `irq`. The next removal clears it.
- R9: `soft_rst` flushes all records and any pending lost count, and clears the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Receiver soft reset; flushes the queue |
| dma_en | input | 1 | Enables recording of frames |
| frm_done | input | 1 | One-cycle end-of-frame strobe from the receiver |
| frm_flags | input | 6 | Receiver flags for the ending frame |
| frm_len | input | 16 | Byte length of the ending frame |
| frm_reject | output | 1 | Receiver must drop new frames |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | Read view select: 0 status, 1 length low/lost count, 2 length high (removes), 3 zero |
| rd_data | output | 8 | Selected byte of the oldest record |
| thr_sel | input | 2 | Interrupt threshold select |
| tmo_limit | input | 16 | Idle cycles before the timeout flag sets |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a saturated lost count that is then drained. To get there, the queue must be filled and held full while several hundred frame strobes arrive, and only then can one record be removed. The bench fills all eight slots and sends 300 more frames. It then pops one record and expects a lost-frame record carrying 255 behind the seven remaining frames. The bench also leaves one cycle after every removal, so the model and the block agree on when the deferred lost record goes in.

// File: rtl/rx_frame_status_fifo.sv
module rx_frame_status_fifo #(
  parameter int DEPTH = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             dma_en,
  input  logic             frm_done,
  input  logic [5:0]       frm_flags,
  input  logic [15:0]      frm_len,
  output logic             frm_reject,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic [7:0]       rd_data,
  input  logic [1:0]       thr_sel,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [23:0]      mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [7:0]       lost_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic             tmo_flag;
  logic [23:0]      push_word, head;
  logic [CW-1:0]    thr_lvl;

  wire full      = (count == FULL_LVL);
  wire empty     = (count == '0);
  wire lost_pend = (lost_cnt != 8'd0);
  wire frm_in    = frm_done & dma_en;
  wire frm_take  = frm_in & ~full & ~lost_pend;
  wire frm_lost  = frm_in & ~frm_take;
  wire lost_push = lost_pend & ~full;
  wire do_push   = frm_take | lost_push;
  wire do_pop    = rd_en & (rd_sel == 2'd2) & ~empty;

  always_comb begin
    if (lost_push) push_word = {2'b10, 6'd0, lost_cnt, 8'h00};
    else           push_word = {2'b00, frm_flags, frm_len[7:0], frm_len[15:8]};
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     lost_cnt <= 8'd0;
    else if (soft_rst)              lost_cnt <= 8'd0;
    else if (lost_push && frm_lost) lost_cnt <= 8'd1;
    else if (lost_push)             lost_cnt <= 8'd0;
    else if (frm_lost && lost_cnt != 8'hFF) lost_cnt <= lost_cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt  <= '0;
      tmo_flag <= 1'b0;
    end else begin
      if (soft_rst || do_push || do_pop || empty) tmo_cnt <= '0;
      else if (tmo_cnt != tmo_limit)             tmo_cnt <= tmo_cnt + 1'b1;
      if (soft_rst || do_pop) tmo_flag <= 1'b0;
      else if (!empty && !do_push && tmo_cnt == tmo_limit) tmo_flag <= 1'b1;
    end
  end

  always_comb begin
    case (thr_sel)
      2'd0:    thr_lvl = CW'(1);
      2'd1:    thr_lvl = CW'(2);
      default: thr_lvl = CW'(4);
    endcase
  end

  assign head = mem[rd_ptr];

  always_comb begin
    rd_data = 8'h00;
    if (!empty) begin
      case (rd_sel)
        2'd0:    rd_data = head[23:16] | 8'h40;
        2'd1:    rd_data = head[15:8];
        2'd2:    rd_data = head[7:0];
        default: rd_data = 8'h00;
      endcase
    end
  end

  assign frm_reject = full | lost_pend;
  assign irq        = (count >= thr_lvl) | tmo_flag;
endmodule

module rx_frame_status_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          dma_en,
  input logic          rd_en,
  input logic [1:0]    rd_sel,
  input logic          frm_reject,
  input logic          irq,
  input logic [CW-1:0] count,
  input logic [7:0]    lost_cnt,
  input logic          tmo_flag
);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> frm_reject);

  p_pop_only_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel != 2'd2 && !dma_en && lost_cnt == 8'd0 && !soft_rst) |=> count == $past(count));

  p_no_dma_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && lost_cnt == 8'd0 && !soft_rst && !rd_en) |=> count == $past(count));

  p_soft_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '0 && lost_cnt == 8'd0 && !tmo_flag && !frm_reject));

  p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd2 && count != '0) |=> !tmo_flag);

  p_lost_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt == 8'hFF && count == CW'(DEPTH) && !soft_rst && !rd_en) |=> lost_cnt == 8'hFF);

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CW'(4)) |-> irq);
endmodule

bind rx_frame_status_fifo rx_frame_status_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dma_en(dma_en),
  .rd_en(rd_en), .rd_sel(rd_sel), .frm_reject(frm_reject), .irq(irq),
  .count(count), .lost_cnt(lost_cnt), .tmo_flag(tmo_flag)
);

// File: tb/rx_frame_status_fifo_test.sv
module rx_frame_status_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, dma_en = 1'b0, frm_done = 1'b0;
  logic [5:0] frm_flags = '0;
  logic [15:0] frm_len = '0;
  logic frm_reject, rd_en = 1'b0, irq;
  logic [1:0] rd_sel = 2'd0, thr_sel = 2'd3;
  logic [7:0] rd_data;
  logic [15:0] tmo_limit = 16'd5000;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  logic [23:0] exp_q [$];
  int m_lost = 0;

  always #5 clk = ~clk;

  rx_frame_status_fifo uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [5:0] fl, logic [15:0] ln);
    frm_flags = fl; frm_len = ln; frm_done = 1'b1;
    if (dma_en) begin
      if (exp_q.size() == 8 || m_lost != 0) m_lost = (m_lost < 255) ? m_lost + 1 : 255;
      else exp_q.push_back({2'b01, fl, ln[7:0], ln[15:8]});
    end
    @(negedge clk);
    frm_done = 1'b0;
  endtask

  task automatic read_entry(string req);
    logic [23:0] e;
    logic [7:0] s0, s1, s2, s0b;
    e = exp_q.pop_front();
    rd_en = 1'b1;
    rd_sel = 2'd0; #1 s0 = rd_data; @(negedge clk);
    rd_sel = 2'd1; #1 s1 = rd_data; @(negedge clk);
    rd_sel = 2'd3; #1; check("R2 view3", {24'd0, rd_data}, 32'd0); @(negedge clk);
    rd_sel = 2'd0; #1 s0b = rd_data; @(negedge clk);
    rd_sel = 2'd2; #1 s2 = rd_data; @(negedge clk);
    rd_en = 1'b0; rd_sel = 2'd0;
    check({req, " status"}, {24'd0, s0}, {24'd0, e[23:16]});
    check({req, " low"},    {24'd0, s1}, {24'd0, e[15:8]});
    check({req, " high"},   {24'd0, s2}, {24'd0, e[7:0]});
    check("R4 status unchanged before hi read", {24'd0, s0b}, {24'd0, s0});
    if (m_lost != 0) begin
      exp_q.push_back({8'hC0, 8'(m_lost), 8'h00});
      m_lost = 0;
    end
    @(negedge clk);
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) read_entry(req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 empty read", {24'd0, rd_data}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 reject", {31'd0, frm_reject}, 32'd0);

    dma_en = 1'b1;
    send_frame(6'h15, 16'h1234);
    send_frame(6'h2A, 16'h00FF);
    send_frame(6'h00, 16'hABCD);
    drain("R2 order");

    dma_en = 1'b0;
    send_frame(6'h3F, 16'h5555);
    #1 check("R3 no record when dma off", {24'd0, rd_data}, 32'd0);
    check("R3 no lost count", {31'd0, frm_reject}, 32'd0);
    dma_en = 1'b1;

    thr_sel = 2'd1;
    send_frame(6'h01, 16'd10);
    #1 check("R7 below thr 2", {31'd0, irq}, 32'd0);
    send_frame(6'h02, 16'd20);
    #1 check("R7 at thr 2", {31'd0, irq}, 32'd1);
    read_entry("R2 thr");
    #1 check("R7 drops below thr", {31'd0, irq}, 32'd0);
    drain("R2 thr");
    thr_sel = 2'd0;
    send_frame(6'h03, 16'd30);
    #1 check("R7 thr 1", {31'd0, irq}, 32'd1);
    drain("R2 thr");
    thr_sel = 2'd2;
    for (int i = 0; i < 3; i++) send_frame(6'(i), 16'(i));
    #1 check("R7 below thr 4", {31'd0, irq}, 32'd0);
    send_frame(6'h04, 16'd4);
    #1 check("R7 at thr 4", {31'd0, irq}, 32'd1);
    drain("R2 thr");
    thr_sel = 2'd3;

    for (int i = 0; i < 8; i++) send_frame(6'(i + 8), 16'(16'h0100 * i + i));
    #1 check("R5 full rejects", {31'd0, frm_reject}, 32'd1);
    for (int i = 0; i < 3; i++) send_frame(6'h3F, 16'hFFFF);
    #1 check("R5 still rejecting", {31'd0, frm_reject}, 32'd1);
    drain("R6 lost 3");
    #1 check("R6 reject released", {31'd0, frm_reject}, 32'd0);

    for (int i = 0; i < 8; i++) send_frame(6'h11, 16'(i + 40));
    for (int i = 0; i < 300; i++) send_frame(6'h22, 16'h7777);
    drain("R6 saturated lost");

    tmo_limit = 16'd20;
    send_frame(6'h05, 16'd77);
    repeat (15) @(negedge clk);
    #1 check("R8 no timeout yet", {31'd0, irq}, 32'd0);
    repeat (10) @(negedge clk);
    #1 check("R8 timeout", {31'd0, irq}, 32'd1);
    read_entry("R8 pop");
    #1 check("R8 cleared by pop", {31'd0, irq}, 32'd0);
    tmo_limit = 16'd5000;

    for (int i = 0; i < 8; i++) send_frame(6'h09, 16'd9);
    send_frame(6'h09, 16'd9);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    exp_q.delete(); m_lost = 0;
    #1 check("R9 flushed", {24'd0, rd_data}, 32'd0);
    check("R9 lost count cleared", {31'd0, frm_reject}, 32'd0);
    check("R1 soft reset irq", {31'd0, irq}, 32'd0);
    send_frame(6'h0A, 16'h0BCD);
    drain("R9 after flush");
    #1 check("R1 empty after drain", {24'd0, rd_data}, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule